// File: doc/BRIEF.md
# Page Write Buffer Controller

This block sits between a two-wire serial memory's protocol engine and its nonvolatile array. During a write transaction it gathers the incoming data bytes into a small page latch. When the transaction closes with a stop condition, it performs one self-timed programming cycle that moves the gathered bytes into the array. The protocol engine passes in three things: the word address that opens the transaction, one strobe for each received data byte, and the stop strobe.

The word address has two parts. Its upper bits select a page, and that page stays fixed for the whole transaction. Its two low bits form a slot pointer that advances after every byte and wraps around inside the four-byte page. If more than four bytes arrive, the later ones overwrite the earlier ones. A mask remembers which slots have been filled. At the start of the programming cycle, one array write is issued per clock for each filled slot, in ascending slot order. The busy output stays high for a parameterised number of clocks, which models the programming time. The protocol engine uses busy to withhold acknowledges, and while busy is high the block ignores all of its inputs.

When strobes coincide, a start strobe wins over a stop strobe, and a stop strobe wins over a byte strobe. A byte that arrives in the same clock as stop is dropped.

Top module: `page_commit_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, busy is 0 and arr_we is 0 until a stop ends a transaction that holds at least one byte.
- R2: Every array write of a commit carries the page bits addr[6:2] of the opening word address. The slot pointer starts at addr[1:0], advances by one per accepted byte, and wraps from 3 to 0.
- R3: When more than four bytes arrive in one transaction, each slot commits the last byte written to it.
- R4: A single byte followed by stop commits exactly one array write, at the opening address.
- R5: Nothing reaches the array before stop. Writes start in the clock after the stop is accepted, one per clock, in ascending slot order 0 to 3. Unfilled slots are skipped, and all writes fall within the first four busy clocks.
- R6: busy rises in the clock after an accepted stop and stays high for exactly WR_CYCLES clocks.
- R7: A stop that arrives after a start but before any data byte starts no write cycle: busy stays 0 and nothing is written.
- R8: While busy is high, start, byte and stop strobes have no effect. They add no array writes, do not change the cycle length, and no later write cycle results from them.
- R9: After a write cycle ends, the slot mask is empty, so the next transaction commits only the slots it fills itself.
- R10: A byte strobe or stop strobe outside an open transaction (no start since the last commit) is ignored and starts no write cycle.
- R11: A start during an open transaction discards the bytes gathered so far and reloads page and pointer from the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_vld | input | 1 | Opens a write transaction with start_addr |
| start_addr | input | 7 | Opening word address: page in [6:2], slot in [1:0] |
| byte_vld | input | 1 | One received data byte |
| byte_data | input | 8 | Data of the received byte |
| stop_vld | input | 1 | Stop condition ending the transaction |
| busy | output | 1 | Programming cycle in progress; inputs ignored |
| arr_we | output | 1 | Array write enable, one clock per committed byte |
| arr_addr | output | 7 | Array word address of the write |
| arr_wdata | output | 8 | Array write data |

## Verification
The commit path is exercised with several transaction shapes:
- A lone byte separates a byte write from a page write.
- A four-byte run that opens at slot 2 shows the wrap of the pointer and the page staying fixed.
- A six-byte run shows overwriting by later bytes.
- A transaction with zero bytes, and byte or stop strobes without a start, show that nothing is committed spuriously.

Strobes driven in the middle of a programming cycle, followed by a one-byte transaction into the same page, separate inputs that are truly ignored from a slot mask that survives the cycle. A repeated start separates discarded bytes from committed ones.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_PROG = 2'd2
  } pwb_state_e;
endpackage

// File: rtl/pwb_rst_sync.sv
module pwb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pwb_slot_latch.sv
module pwb_slot_latch #(
  parameter int PAGE_BYTES = 4,
  parameter int DATA_W     = 8,
  localparam int SLOT_W    = $clog2(PAGE_BYTES)
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 clr,
  input  logic                                 wr_en,
  input  logic [SLOT_W-1:0]                    wr_slot,
  input  logic [DATA_W-1:0]                    wr_data,
  output logic [PAGE_BYTES-1:0][DATA_W-1:0]    slot_data,
  output logic [PAGE_BYTES-1:0]                slot_mask
);
  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_slot == SLOT_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   slot_mask[g] <= 1'b0;
      else if (clr) slot_mask[g] <= 1'b0;
      else if (hit) slot_mask[g] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (hit) slot_data[g] <= wr_data;
    end
  end
endmodule

// File: rtl/pwb_prog_timer.sv
module pwb_prog_timer #(
  parameter int WR_CYCLES = 625000,
  parameter int CNT_W     = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  output logic [CNT_W-1:0] cnt,
  output logic             done
);
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    if (run) cnt_d = cnt + CNT_W'(1);
    else     cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  assign done = run && (cnt == CNT_W'(WR_CYCLES - 1));
endmodule

// File: rtl/pwb_sequencer.sv
module pwb_sequencer
  import pwb_pkg::*;
#(
  parameter int ADDR_W  = 7,
  parameter int SLOT_W  = 2,
  localparam int PAGE_W = ADDR_W - SLOT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_vld,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              byte_vld,
  input  logic              stop_vld,
  input  logic              any_filled,
  input  logic              prog_done,
  output pwb_state_e        state,
  output logic [PAGE_W-1:0] page_q,
  output logic [SLOT_W-1:0] slot_q,
  output logic              latch_wr,
  output logic              latch_clr
);
  pwb_state_e        state_d;
  logic [PAGE_W-1:0] page_d;
  logic [SLOT_W-1:0] slot_d;
  logic              load_en;

  always_comb begin
    state_d   = state;
    page_d    = page_q;
    slot_d    = slot_q;
    load_en   = 1'b0;
    latch_wr  = 1'b0;
    latch_clr = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start_vld) begin
          state_d   = ST_FILL;
          load_en   = 1'b1;
          latch_clr = 1'b1;
        end
      end
      ST_FILL: begin
        if (start_vld) begin
          load_en   = 1'b1;
          latch_clr = 1'b1;
        end else if (stop_vld) begin
          if (any_filled) begin
            state_d = ST_PROG;
          end else begin
            state_d   = ST_IDLE;
            latch_clr = 1'b1;
          end
        end else if (byte_vld) begin
          latch_wr = 1'b1;
          slot_d   = slot_q + SLOT_W'(1);
        end
      end
      ST_PROG: begin
        if (prog_done) begin
          state_d   = ST_IDLE;
          latch_clr = 1'b1;
        end
      end
      default: begin
        state_d   = ST_IDLE;
        latch_clr = 1'b1;
      end
    endcase
    if (load_en) begin
      page_d = start_addr[ADDR_W-1:SLOT_W];
      slot_d = start_addr[SLOT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      page_q <= '0;
      slot_q <= '0;
    end else begin
      state  <= state_d;
      page_q <= page_d;
      slot_q <= slot_d;
    end
  end
endmodule

// File: rtl/page_commit_ctrl.sv
module page_commit_ctrl
  import pwb_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 4,
  parameter int WR_CYCLES  = 625000,
  localparam int SLOT_W    = $clog2(PAGE_BYTES),
  localparam int PAGE_W    = ADDR_W - SLOT_W,
  localparam int CW_RAW    = $clog2(WR_CYCLES + 1),
  localparam int CNT_W     = (CW_RAW > SLOT_W) ? CW_RAW : SLOT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_vld,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              stop_vld,
  output logic              busy,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata
);
  logic                              rst_sync_n;
  pwb_state_e                        state;
  logic [PAGE_W-1:0]                 page_q;
  logic [SLOT_W-1:0]                 slot_q;
  logic                              latch_wr;
  logic                              latch_clr;
  logic [PAGE_BYTES-1:0][DATA_W-1:0] slot_data;
  logic [PAGE_BYTES-1:0]             slot_mask;
  logic                              prog_run;
  logic [CNT_W-1:0]                  prog_cnt;
  logic                              prog_done;
  logic [SLOT_W-1:0]                 drain_slot;
  logic                              drain_window;

  pwb_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pwb_sequencer #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start_vld  (start_vld),
    .start_addr (start_addr),
    .byte_vld   (byte_vld),
    .stop_vld   (stop_vld),
    .any_filled (|slot_mask),
    .prog_done  (prog_done),
    .state      (state),
    .page_q     (page_q),
    .slot_q     (slot_q),
    .latch_wr   (latch_wr),
    .latch_clr  (latch_clr)
  );

  pwb_slot_latch #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_latch (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clr       (latch_clr),
    .wr_en     (latch_wr),
    .wr_slot   (slot_q),
    .wr_data   (byte_data),
    .slot_data (slot_data),
    .slot_mask (slot_mask)
  );

  assign prog_run = (state == ST_PROG);

  pwb_prog_timer #(.WR_CYCLES(WR_CYCLES), .CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (prog_run),
    .cnt   (prog_cnt),
    .done  (prog_done)
  );

  // The first PAGE_BYTES clocks of the cycle walk the slots in order.
  assign drain_slot   = prog_cnt[SLOT_W-1:0];
  assign drain_window = (prog_cnt < CNT_W'(PAGE_BYTES));

  assign busy      = prog_run;
  assign arr_we    = prog_run && drain_window && slot_mask[drain_slot];
  assign arr_addr  = {page_q, drain_slot};
  assign arr_wdata = slot_data[drain_slot];
endmodule

// File: rtl/page_commit_ctrl_chk.sv
module page_commit_ctrl_chk #(
  parameter int ADDR_W     = 7,
  parameter int PAGE_BYTES = 4,
  parameter int WR_CYCLES  = 625000,
  localparam int SLOT_W    = $clog2(PAGE_BYTES)
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              stop_vld,
  input logic              busy,
  input logic              arr_we,
  input logic [ADDR_W-1:0] arr_addr
);
  logic [31:0] run_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) run_q <= '0;
    else if (busy)   run_q <= run_q + 32'd1;
    else             run_q <= '0;
  end

  p_we_needs_busy_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    arr_we |-> busy);

  p_we_in_window_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    arr_we |-> (run_q < PAGE_BYTES));

  p_we_ascending_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (arr_we && $past(arr_we) && $past(busy)) |->
      (arr_addr[SLOT_W-1:0] == $past(arr_addr[SLOT_W-1:0]) + SLOT_W'(1)));

  p_page_stable_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy && $past(busy)) |-> $stable(arr_addr[ADDR_W-1:SLOT_W]));

  p_busy_after_stop_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(busy) |-> $past(stop_vld));

  p_busy_length_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(busy) |-> (run_q == WR_CYCLES));
endmodule

bind page_commit_ctrl page_commit_ctrl_chk #(
  .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .WR_CYCLES(WR_CYCLES)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .stop_vld   (stop_vld),
  .busy       (busy),
  .arr_we     (arr_we),
  .arr_addr   (arr_addr)
);

// File: tb/page_commit_ctrl_bench.sv
module page_commit_ctrl_bench;
  localparam int WR = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_vld = 1'b0;
  logic [6:0] start_addr = '0;
  logic       byte_vld = 1'b0;
  logic [7:0] byte_data = '0;
  logic       stop_vld = 1'b0;
  logic       busy, arr_we;
  logic [6:0] arr_addr;
  logic [7:0] arr_wdata;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [14:0] exp_q[$];
  string       tag_q[$];

  logic [4:0] m_page;
  logic [1:0] m_ptr;
  logic [7:0] m_data [4];
  logic [3:0] m_mask;
  bit         m_open = 1'b0;

  always #4 clk = ~clk;

  page_commit_ctrl #(.WR_CYCLES(WR)) u_page_commit_ctrl (
    .clk(clk), .rst_n(rst_n), .start_vld(start_vld), .start_addr(start_addr),
    .byte_vld(byte_vld), .byte_data(byte_data), .stop_vld(stop_vld),
    .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every array write, times busy runs.
  int busy_run = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (arr_we) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R5", "unexpected array write", {arr_addr, arr_wdata}, 0);
        end else begin
          logic [14:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({arr_addr, arr_wdata} == e, t, "array write {addr,data}",
                {arr_addr, arr_wdata}, e);
        end
      end
      if (busy) busy_run++;
      else if (busy_run != 0) begin
        check(busy_run == WR, "R6", "busy length", busy_run, WR);
        busy_run = 0;
      end
    end
  end

  task automatic raw_pulse(input bit s, input logic [6:0] a, input bit b,
                           input logic [7:0] d, input bit p);
    @(negedge clk);
    start_vld = s; start_addr = a; byte_vld = b; byte_data = d; stop_vld = p;
    @(negedge clk);
    start_vld = 0; byte_vld = 0; stop_vld = 0;
  endtask

  task automatic t_start(input logic [6:0] a);
    m_open = 1'b1; m_page = a[6:2]; m_ptr = a[1:0]; m_mask = '0;
    raw_pulse(1, a, 0, 8'h00, 0);
  endtask

  task automatic t_byte(input logic [7:0] d);
    if (m_open) begin
      m_data[m_ptr] = d; m_mask[m_ptr] = 1'b1; m_ptr = m_ptr + 2'd1;
    end
    raw_pulse(0, 7'h00, 1, d, 0);
  endtask

  // Ends a transaction; poke drives stray strobes mid-cycle.
  task automatic t_stop(input string tag, input bit poke);
    bit commit;
    commit = m_open && (m_mask != 0);
    if (commit) begin
      for (int i = 0; i < 4; i++)
        if (m_mask[i]) begin
          exp_q.push_back({m_page, 2'(i), m_data[i]});
          tag_q.push_back(tag);
        end
    end
    m_open = 1'b0; m_mask = '0;
    @(negedge clk);
    stop_vld = 1'b1;
    @(negedge clk);
    stop_vld = 1'b0;
    if (commit) begin
      check(busy == 1'b1, "R6", "busy the clock after stop", busy, 1);
      if (poke) begin
        raw_pulse(1, 7'h50, 0, 8'h00, 0);
        raw_pulse(0, 7'h00, 1, 8'h99, 0);
        raw_pulse(0, 7'h00, 0, 8'h00, 1);
      end
      for (int k = 0; k < WR + 10 && busy; k++) @(negedge clk);
      check(exp_q.size() == 0, tag, "writes pending after cycle", exp_q.size(), 0);
      if (poke) begin
        repeat (4) @(negedge clk);
        check(busy == 1'b0, "R8", "stray stop caused a cycle", busy, 0);
      end
    end else begin
      repeat (4) @(negedge clk);
      check(busy == 1'b0, tag, "busy without bytes", busy, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && arr_we == 1'b0, "R1", "outputs in reset", {busy, arr_we}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(busy == 1'b0 && arr_we == 1'b0, "R1", "outputs after reset", {busy, arr_we}, 0);

    // R4: byte write
    t_start(7'h25); t_byte(8'hA5); t_stop("R4", 0);
    // R2: page write opening at slot 2 wraps to slot 0
    t_start(7'h2E); t_byte(8'h11); t_byte(8'h22); t_byte(8'h33); t_byte(8'h44);
    t_stop("R2", 0);
    // R3: six bytes overwrite slots 0 and 1
    t_start(7'h40);
    for (int i = 1; i <= 6; i++) t_byte(8'(i));
    t_stop("R3", 0);
    // R7: no bytes
    t_start(7'h33); t_stop("R7", 0);
    // R8: strobes during busy ignored; R9: mask empty afterwards
    t_start(7'h10); t_byte(8'h5C); t_stop("R8", 1);
    t_start(7'h13); t_byte(8'hC3); t_stop("R9", 0);
    // R10: byte and stop with no open transaction
    t_byte(8'h77); t_stop("R10", 0);
    // R11: repeated start discards earlier bytes
    t_start(7'h08); t_byte(8'hAA); t_start(7'h31); t_byte(8'hBB); t_stop("R11", 0);
    // R5: longer page write, only filled slots 1..3 in order
    t_start(7'h75); t_byte(8'hD1); t_byte(8'hD2); t_byte(8'hD3); t_stop("R5", 0);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule